// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a first-in first-out buffer between two unrelated clock domains. The writer pushes 36-bit words on its own clock. The reader pulls them out on a second clock. Each side sees its own status flags: full and almost-full on the write side, empty and almost-empty on the read side. The two pointers cross between the domains as Gray code through two-flop synchronizers. The read port is in standard mode: the word appears on the output one read-clock edge after a read is accepted.

The reader can replay the stream. It drives the active-low rewind input low for at least one read-clock cycle and then high again, synchronously to the read clock. On the rising edge the read pointer returns to address zero, its value at reset. The words written since reset then come out again, in order. A rewind is honoured only while fewer than depth minus two words have been written since reset. Past that count the rewind is refused and a sticky error output rises.

While a rewind is in progress, and for a short recovery interval after it, reads are held off and writes are masked. A write attempted in that window is dropped and raises a sticky violation flag. Both clocks run freely throughout.

Top module: `rewind_fifo`

## Requirements
- R1: While rstN is low and after its release, empty=1, almostEmpty=1, full=0, almostFull=0, rtErr=0 and wrViol=0.
- R2: A write is stored only when wrEn=1, full=0 and no rewind window is active. full rises once DEPTH words are held. A write while full is dropped.
- R3: A read with rdEn=1 and empty=0, outside a rewind window, puts the next word on rdData at the following read-clock edge. A read while empty leaves rdData unchanged.
- R4: Words leave in the order they were written, bit-exact across all 36 bits.
- R5: almostFull is high when the write side's fill level is at least DEPTH-AF_TH (14 at defaults).
- R6: almostEmpty is high when the read side's fill level is at most AE_TH (2 at defaults).
- R7: When rtN rises after at least one low read-clock cycle, and fewer than DEPTH-2 words have been written since reset, the read pointer returns to zero. The next reads return the first word written after reset, then the following words in order.
- R8: While rtN is low and for RT_REC read-clock cycles after it rises, rdEn has no effect and rdData holds its value.
- R9: Writes are masked from within three write-clock cycles after rtN falls until the end of recovery. A write attempted in that window is not stored and sets wrViol, which stays high until reset.
- R10: When DEPTH-2 or more words have been written since reset, a rewind leaves the read pointer unchanged and sets rtErr, which stays high until reset.
- R11: Each pointer crosses domains as Gray code: the write pointer changes by at most one bit per write clock, and the read pointer does too except on a rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Word to store |
| full | output | 1 | FIFO holds DEPTH words (write domain) |
| almostFull | output | 1 | Fill level at or above DEPTH-AF_TH (write domain) |
| wrViol | output | 1 | Sticky: a write was attempted inside the rewind window |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Word read out, registered |
| empty | output | 1 | No word available (read domain) |
| almostEmpty | output | 1 | Fill level at or below AE_TH (read domain) |
| rtN | input | 1 | Active-low rewind strobe, synchronous to rdClk |
| rtErr | output | 1 | Sticky: a rewind was refused because too many words were written |

## Verification
On every cycle, the assertions check the following:
- Full and empty only clear when the opposite pointer's synchronized copy moves.
- Each pointer steps by one Gray bit, except on a rewind.
- rdData holds steady when no read is accepted.
- The error and violation flags stay set once raised.

Only the bench scenarios can show the rest:
- that a rewind actually replays the original words in order;
- that the write masked during the rewind window leaves no trace in the replay;
- that the almost thresholds switch at the right fill levels;
- that a rewind after too many writes is refused.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } memStb_t;

  // Rewind sequencer states (read domain).
  typedef enum logic [1:0] {
    RT_IDLE,
    RT_HOLD,
    RT_RECOVER
  } rtState_t;

endpackage

// File: rtl/rewind_fifo_mem.sv
module rewind_fifo_mem
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  memStb_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= store[rdAddr];
  end

  // R3 / R8: output only moves on an accepted read
  p_rddata_hold_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdData));

endmodule

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AE_TH  = 2,
  parameter int AF_TH  = 2,
  parameter int RT_REC = 3
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rtN,
  output memStb_t           stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              almostFull,
  output logic              wrViol,
  output logic              empty,
  output logic              almostEmpty,
  output logic              rtErr
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int REC_W = $clog2(RT_REC + 1);
  localparam logic [PW-1:0] WR_LIMIT = PW'(DEPTH - 2);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_TH);
  localparam logic [PW-1:0] AE_LVL   = PW'(AE_TH);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGrayW1, rdGrayW2, levelW, wrCnt;
  logic          busyW1, busyW2, tooManyW;
  logic          rdBusy, rdBusyQ;

  assign full     = (wrGray == {~rdGrayW2[PW-1:PW-2], rdGrayW2[PW-3:0]});
  assign stb.wrStb = wrEn && !full && !busyW2;
  assign wrAddr   = wrBin[ADDR_W-1:0];
  assign levelW   = wrBin - gray2bin(rdGrayW2);
  assign tooManyW = (wrCnt == WR_LIMIT);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      rdGrayW1   <= '0;
      rdGrayW2   <= '0;
      busyW1     <= 1'b0;
      busyW2     <= 1'b0;
      wrCnt      <= '0;
      wrViol     <= 1'b0;
      almostFull <= 1'b0;
    end else begin
      rdGrayW1   <= rdGray;
      rdGrayW2   <= rdGrayW1;
      busyW1     <= rdBusyQ;
      busyW2     <= busyW1;
      almostFull <= (levelW >= AF_LVL);
      if (stb.wrStb) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= bin2gray(wrBin + 1'b1);
        if (!tooManyW) wrCnt <= wrCnt + 1'b1;
      end
      if (wrEn && busyW2) wrViol <= 1'b1;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0]    rdBin, rdGray, wrGrayR1, wrGrayR2, levelR;
  logic             tooManyR1, tooManyR2;
  logic [REC_W-1:0] recCnt;
  rtState_t         rtState;

  assign empty     = (rdGray == wrGrayR2);
  assign rdBusy    = (rtState != RT_IDLE) || !rtN;
  assign stb.rdStb = rdEn && !empty && !rdBusy;
  assign rdAddr    = rdBin[ADDR_W-1:0];
  assign levelR    = gray2bin(wrGrayR2) - rdBin;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGrayR1    <= '0;
      wrGrayR2    <= '0;
      tooManyR1   <= 1'b0;
      tooManyR2   <= 1'b0;
      rdBusyQ     <= 1'b0;
      recCnt      <= '0;
      rtErr       <= 1'b0;
      almostEmpty <= 1'b1;
      rtState     <= RT_IDLE;
    end else begin
      wrGrayR1    <= wrGray;
      wrGrayR2    <= wrGrayR1;
      tooManyR1   <= tooManyW;
      tooManyR2   <= tooManyR1;
      rdBusyQ     <= rdBusy;
      almostEmpty <= (levelR <= AE_LVL);
      if (stb.rdStb) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= bin2gray(rdBin + 1'b1);
      end
      unique case (rtState)
        RT_IDLE: if (!rtN) rtState <= RT_HOLD;
        RT_HOLD: if (rtN) begin
          if (tooManyR2) begin
            rtErr <= 1'b1;
          end else begin
            rdBin  <= '0;
            rdGray <= '0;
          end
          recCnt  <= '0;
          rtState <= RT_RECOVER;
        end
        RT_RECOVER: begin
          if (recCnt == REC_W'(RT_REC - 1)) rtState <= RT_IDLE;
          else                              recCnt  <= recCnt + 1'b1;
        end
        default: rtState <= RT_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R2: full only clears when the synchronized read pointer moves
  p_full_holds_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    full |=> full || (rdGrayW2 != $past(rdGrayW2)));

  // R3: empty only clears when a pointer moves
  p_empty_holds_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |=> empty || (wrGrayR2 != $past(wrGrayR2)) || (rdGray != $past(rdGray)));

  // R11: write pointer is a single-bit Gray step
  p_wr_gray_step_r11: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wrGray ^ $past(wrGray)));

  // R11: read pointer is a single-bit Gray step except on a rewind
  p_rd_gray_step_r11: assert property (@(posedge rdClk) disable iff (!rstN)
    (rtState != RT_HOLD) |=> $onehot0(rdGray ^ $past(rdGray)));

  // R9: violation flag is sticky
  p_viol_sticky_r9: assert property (@(posedge wrClk) disable iff (!rstN)
    wrViol |=> wrViol);

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge rdClk) disable iff (!rstN)
    rtErr |=> rtErr);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rewind_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4,
  parameter int AE_TH  = 2,
  parameter int AF_TH  = 2,
  parameter int RT_REC = 3
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic              almostFull,
  output logic              wrViol,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  input  logic              rtN,
  output logic              rtErr
);

  memStb_t           stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  rewind_fifo_ctrl #(
    .ADDR_W(ADDR_W), .AE_TH(AE_TH), .AF_TH(AF_TH), .RT_REC(RT_REC)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn), .rtN(rtN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull), .wrViol(wrViol),
    .empty(empty), .almostEmpty(almostEmpty), .rtErr(rtErr)
  );

  rewind_fifo_mem #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) mem_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;

  localparam int DW    = 36;
  localparam int DEPTH = 16;

  logic          wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0, rtN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          full, almostFull, wrViol, empty, almostEmpty, rtErr;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] firstWords[$];

  always #2 wrClk = ~wrClk;   // 250 MHz write clock
  always #3 rdClk = ~rdClk;

  rewind_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .full(full), .almostFull(almostFull), .wrViol(wrViol),
    .rdEn(rdEn), .rdData(rdData), .empty(empty), .almostEmpty(almostEmpty),
    .rtN(rtN), .rtErr(rtErr)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; rtN = 1'b1;
    expQ.delete(); firstWords.delete();
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    repeat (3) @(negedge rdClk);
  endtask

  // Driver: writes one word and records it in the scoreboard
  task automatic writeWord(logic [DW-1:0] d);
    @(negedge wrClk);
    while (full) @(negedge wrClk);
    wrEn = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
    expQ.push_back(d);
    firstWords.push_back(d);
  endtask

  // Monitor: reads one word and compares it with the scoreboard head
  task automatic readWord(string req);
    logic [DW-1:0] exp;
    @(negedge rdClk);
    while (empty) @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    if (expQ.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s: actual=%h expected=<queue empty>", req, rdData);
    end else begin
      exp = expQ.pop_front();
      check(req, rdData, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  task automatic rewind(int lowCycles);
    @(negedge rdClk);
    rtN = 1'b0;
    repeat (lowCycles) @(negedge rdClk);
    rtN = 1'b1;
    repeat (10) @(negedge rdClk);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;

    // ---------- R1 reset state ----------
    #1;
    check("R1 empty in reset", DW'(empty), DW'(1));
    check("R1 full in reset",  DW'(full),  DW'(0));
    doReset();
    check("R1 empty", DW'(empty), DW'(1));
    check("R1 almostEmpty", DW'(almostEmpty), DW'(1));
    check("R1 full", DW'(full), DW'(0));
    check("R1 almostFull", DW'(almostFull), DW'(0));
    check("R1 rtErr", DW'(rtErr), DW'(0));
    check("R1 wrViol", DW'(wrViol), DW'(0));

    // ---------- R3 read while empty ----------
    held = rdData;
    @(negedge rdClk); rdEn = 1'b1; @(negedge rdClk); rdEn = 1'b0;
    check("R3 read while empty holds rdData", rdData, held);

    // ---------- R6 almost-empty threshold ----------
    writeWord({4'h1, 32'h0000_0000});
    writeWord({4'h2, 32'hFFFF_FFFF});
    settle();
    check("R6 almostEmpty at level 2", DW'(almostEmpty), DW'(1));
    writeWord({4'h3, 32'hA5A5_5A5A});
    settle();
    check("R6 almostEmpty clear at level 3", DW'(almostEmpty), DW'(0));

    // ---------- R5 almost-full threshold ----------
    for (int i = 3; i < 13; i++) writeWord({4'h4, 32'(i * 32'h0101_0101)});
    repeat (4) @(negedge wrClk);
    check("R5 almostFull clear at level 13", DW'(almostFull), DW'(0));
    writeWord({4'h5, 32'h1234_5678});
    repeat (4) @(negedge wrClk);
    check("R5 almostFull at level 14", DW'(almostFull), DW'(1));

    // ---------- R2 full and dropped write ----------
    writeWord({4'h6, 32'h8765_4321});
    check("R2 full clear at 15", DW'(full), DW'(0));
    writeWord({4'h7, 32'hDEAD_BEEF});
    check("R2 full at DEPTH", DW'(full), DW'(1));
    @(negedge wrClk); wrEn = 1'b1; wrData = {4'hF, 32'hBAD0_BAD0};
    @(negedge wrClk); wrEn = 1'b0;

    // ---------- R3 / R4 drain in order ----------
    for (int i = 0; i < DEPTH; i++) readWord("R4 order");
    settle();
    check("R2 write while full dropped (empty after DEPTH reads)", DW'(empty), DW'(1));
    check("R3 queue drained", DW'(expQ.size()), DW'(0));

    // ---------- R7 / R8 / R9 rewind replay ----------
    doReset();
    for (int i = 0; i < 5; i++) writeWord({4'h9, 32'(32'hC000_0000 + i)});
    readWord("R3 read");
    readWord("R3 read");
    settle();
    held = rdData;
    @(negedge rdClk);
    rtN = 1'b0;
    repeat (6) @(negedge wrClk);
    wrEn = 1'b1; wrData = {4'hE, 32'hFEED_FACE};
    @(negedge wrClk); wrEn = 1'b0;
    @(negedge rdClk); rdEn = 1'b1; @(negedge rdClk); rdEn = 1'b0;
    check("R8 read during rewind ignored", rdData, held);
    repeat (4) @(negedge rdClk);
    rtN = 1'b1;
    @(negedge rdClk); rdEn = 1'b1; @(negedge rdClk); rdEn = 1'b0;
    check("R8 read during recovery ignored", rdData, held);
    repeat (10) @(negedge rdClk);
    check("R9 wrViol set", DW'(wrViol), DW'(1));
    check("R7 not empty after rewind", DW'(empty), DW'(0));
    check("R10 rtErr clear on valid rewind", DW'(rtErr), DW'(0));
    expQ.delete();
    foreach (firstWords[i]) expQ.push_back(firstWords[i]);
    for (int i = 0; i < 5; i++) readWord("R7 replay");
    settle();
    check("R9 masked write not stored", DW'(empty), DW'(1));
    check("R9 wrViol sticky", DW'(wrViol), DW'(1));

    // ---------- R10 refused rewind ----------
    doReset();
    for (int i = 0; i < DEPTH - 2; i++) writeWord({4'hB, 32'(i * 32'h0011_0011)});
    for (int i = 0; i < DEPTH - 2; i++) readWord("R4 order");
    settle();
    rewind(3);
    check("R10 rtErr set", DW'(rtErr), DW'(1));
    check("R10 pointer not rewound", DW'(empty), DW'(1));
    check("R9 no violation without write", DW'(wrViol), DW'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule